// File: doc/BRIEF.md
# Dead-Time PWM Channel with Shadow Registers

A single pulse-width modulation channel that drives a complementary high-side/low-side output pair. A period counter runs left-aligned (sawtooth) or center-aligned (up/down triangle). A duty comparator turns the count into a raw waveform. An optional dead-time stage then holds each output off for a programmable number of clocks after the other one releases. A power-of-two clock prescaler sets the counter rate.

Configuration arrives through a simple register-write port. While the channel is stopped, period, duty and dead-time writes load the live settings directly. While it runs, those writes land in shadow copies. The shadow copies are transferred at the end of each full counter cycle, so a waveform never mixes old and new settings. A stop request lets the current cycle finish before the channel halts. A one-clock `period_end` pulse marks cycle ends and can serve as an interrupt source.

Top module: `dtpwm_chan`

## Requirements
- R1: After reset, `running` is 0, `period_end` is 0, and both outputs are 0. While stopped, `pwm_hi` equals the high-invert mode bit, `pwm_lo` equals the low-invert mode bit, and `period_end` stays 0.
- R2: Left-aligned mode (mode bit 0 = 0). The counter counts 0 up to P-1 and wraps, where P ≥ 1 is the period. The raw waveform is active while count < D, where D is the duty. A duty equal to P gives a waveform that is always active. A duty of 0 gives one that is never active. `period_end` is high for exactly the last clock of each period.
- R3: Center-aligned mode (mode bit 0 = 1). The counter climbs 0 to P, then descends to 1, so one full cycle lasts 2P ticks. `period_end` is high in the last tick of the cycle. When mode bit 5 is set, `period_end` is also high in the tick where the rising count equals P-1.
- R4: Mode bit 1 inverts the raw waveform. With dead-time off (mode bit 2 = 0), the high side equals the raw waveform and the low side equals its complement. Mode bit 3 then inverts the high pin and mode bit 4 inverts the low pin.
- R5: With mode bit 2 set, the dead-time word is used. Its bits 15:0 hold the high-side delay H and its bits 31:16 hold the low-side delay L, both counted in clocks. The high side becomes active H clocks after the raw waveform rises. The low side becomes active L clocks after the raw waveform falls. A delay of 0 gives no delay.
- R6: Before the pin inversion, the high side and the low side are never active in the same clock.
- R7: While stopped, writes to period (select 1), duty (select 2) and dead-time (select 3) take effect at once. While running, they take effect only after the next full-cycle end.
- R8: A mode write (select 0) while running is ignored.
- R9: A stop write (select 5) leaves the channel running until the current full cycle ends. `running` falls in the clock after the final `period_end`, and the outputs return to their stopped levels. A start write is select 4.
- R10: Mode bits 11:8 hold an exponent n. The counter advances once every 2^n clocks, and `period_end` falls in the last clock of the final count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 mode, 1 period, 2 duty, 3 dead-time, 4 start, 5 stop |
| wr_data | input | 2*CW | Write data |
| pwm_hi | output | 1 | High-side output |
| pwm_lo | output | 1 | Low-side output |
| running | output | 1 | Channel active status |
| period_end | output | 1 | One-clock end-of-cycle pulse |

## Verification
All outputs are decoded from registers only. The clock after the start write's edge is therefore cycle 0 of the waveform, with the count at 0. A shadowed write shows up in the first clock after the edge that closes the cycle's final tick. After a stop write, `running` drops one clock after the last `period_end`. Immediately after each start edge, the bench queues one expected output vector per clock. These vectors come from the period, duty and dead-time formulas. A falling-edge monitor pops one vector per clock and compares it, so each expectation lands exactly on the clock in which the registered state shows it.

// File: rtl/dtpwm_chan.sv
module dtpwm_chan #(
  parameter int CW  = 16,
  parameter int PSW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [2*CW-1:0] wr_data,
  output logic            pwm_hi,
  output logic            pwm_lo,
  output logic            running,
  output logic            period_end
);
  localparam int MW  = 6 + PSW;
  localparam int PCW = (1 << PSW) - 1;
  localparam logic [2:0] SEL_MODE = 3'd0, SEL_PRD = 3'd1, SEL_DTY = 3'd2,
                         SEL_DT = 3'd3, SEL_ON = 3'd4, SEL_OFF = 3'd5;

  logic [MW-1:0]  mode_q;
  logic [CW-1:0]  prd_a, dty_a, dth_a, dtl_a;
  logic [CW-1:0]  prd_s, dty_s, dth_s, dtl_s;
  logic [CW-1:0]  cnt, dcnt, dt_new;
  logic [PCW-1:0] pre_cnt, pre_mask;
  logic run, dis_pend, down, raw_d;
  logic tick, last_up, bnd, mid, stop, raw, chg, dt_ok, hi_act, lo_act;
  logic wr_on, wr_off;

  wire           m_ctr  = mode_q[0];
  wire           m_pol  = mode_q[1];
  wire           m_dte  = mode_q[2];
  wire           m_invh = mode_q[3];
  wire           m_invl = mode_q[4];
  wire           m_mid  = mode_q[5];
  wire [PSW-1:0] m_psc  = mode_q[6 +: PSW];

  assign wr_on    = wr_en && (wr_sel == SEL_ON);
  assign wr_off   = wr_en && (wr_sel == SEL_OFF);
  assign pre_mask = {PCW{1'b1}} >> (PCW - int'(m_psc));
  assign tick     = run && ((pre_cnt & pre_mask) == pre_mask);
  assign last_up  = (cnt == prd_a - 1'b1);
  assign bnd      = tick && (m_ctr ? (down && cnt == CW'(1)) : last_up);
  assign mid      = tick && m_ctr && m_mid && !down && last_up;
  assign stop     = bnd && (dis_pend || wr_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      dis_pend <= 1'b0;
    end else if (wr_on) begin
      run      <= 1'b1;
      dis_pend <= 1'b0;
    end else if (stop) begin
      run      <= 1'b0;
      dis_pend <= 1'b0;
    end else if (wr_off && run) begin
      dis_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      prd_a  <= CW'(1);
      prd_s  <= CW'(1);
      dty_a  <= '0;
      dty_s  <= '0;
      dth_a  <= '0;
      dth_s  <= '0;
      dtl_a  <= '0;
      dtl_s  <= '0;
    end else begin
      if (bnd) begin
        prd_a <= prd_s;
        dty_a <= dty_s;
        dth_a <= dth_s;
        dtl_a <= dtl_s;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_MODE: if (!run) mode_q <= {wr_data[8 +: PSW], wr_data[5:0]};
          SEL_PRD: begin
            prd_s <= wr_data[CW-1:0];
            if (!run) prd_a <= wr_data[CW-1:0];
          end
          SEL_DTY: begin
            dty_s <= wr_data[CW-1:0];
            if (!run) dty_a <= wr_data[CW-1:0];
          end
          SEL_DT: begin
            dth_s <= wr_data[CW-1:0];
            dtl_s <= wr_data[2*CW-1:CW];
            if (!run) begin
              dth_a <= wr_data[CW-1:0];
              dtl_a <= wr_data[2*CW-1:CW];
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      down    <= 1'b0;
      pre_cnt <= '0;
    end else if (!run) begin
      cnt     <= '0;
      down    <= 1'b0;
      pre_cnt <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (bnd) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (tick) begin
        if (m_ctr && down) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (m_ctr && last_up) down <= 1'b1;
        end
      end
    end
  end

  assign raw    = run && ((cnt < dty_a) ^ m_pol);
  assign chg    = raw != raw_d;
  assign dt_new = raw ? dth_a : dtl_a;
  assign dt_ok  = chg ? (dt_new == '0) : (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_d <= 1'b0;
      dcnt  <= '0;
    end else if (!run) begin
      raw_d <= 1'b0;
      dcnt  <= '0;
    end else begin
      raw_d <= raw;
      if (chg)
        dcnt <= (dt_new == '0) ? '0 : dt_new - 1'b1;
      else if (dcnt != '0)
        dcnt <= dcnt - 1'b1;
    end
  end

  assign hi_act     = run && (m_dte ? (raw && dt_ok) : raw);
  assign lo_act     = run && (m_dte ? (!raw && dt_ok) : !raw);
  assign pwm_hi     = hi_act ^ m_invh;
  assign pwm_lo     = lo_act ^ m_invl;
  assign running    = run;
  assign period_end = bnd || mid;
endmodule

// File: rtl/dtpwm_chan_chk.sv
module dtpwm_chan_chk #(
  parameter int CW = 16,
  parameter int MW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          period_end,
  input logic          hi_act,
  input logic          lo_act,
  input logic          bnd,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] prd_a,
  input logic [CW-1:0] dty_a,
  input logic [MW-1:0] mode_q
);
  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_act && lo_act));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= prd_a));

  // R2
  pulse_when_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> running);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !bnd) |=> ($stable(prd_a) && $stable(dty_a)));

  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(mode_q));

  // R9
  stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(period_end));
endmodule

bind dtpwm_chan dtpwm_chan_chk #(.CW(CW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .period_end(period_end),
  .hi_act(hi_act), .lo_act(lo_act), .bnd(bnd), .cnt(cnt),
  .prd_a(prd_a), .dty_a(dty_a), .mode_q(mode_q)
);

// File: tb/dtpwm_chan_bench.sv
module dtpwm_chan_bench;
  localparam int CLK_NS = 10;

  typedef struct {
    logic [3:0] v;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic pwm_hi, pwm_lo, running, period_end;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit m_prev;
  int m_len;

  always #(CLK_NS/2) clk = ~clk;

  dtpwm_chan u_dtpwm_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .running(running), .period_end(period_end)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got hi/lo/pe/run=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, {pwm_hi, pwm_lo, period_end, running}, it.v);
    end
  end

  function automatic logic [31:0] md(bit ctr, bit pol, bit dte, bit ih, bit il, bit mid, int psc);
    md = {20'd0, 4'(psc), 2'b00, mid, il, ih, dte, pol, ctr};
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] mode, input int p, input int d, input int dth, input int dtl);
    wr(3'd0, mode);
    wr(3'd1, 32'(p));
    wr(3'd2, 32'(d));
    wr(3'd3, {16'(dtl), 16'(dth)});
  endtask

  task automatic start();
    wr(3'd4, 32'd0);
    m_prev = 1'b0;
    m_len = 1 << 20;
  endtask

  task automatic flush();
    while (q.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic halt();
    flush();
    wr(3'd5, 32'd0);
    do @(negedge clk); while (running);
    @(posedge clk); #1;
  endtask

  task automatic gen(input int p, input int d, input bit ctr, input bit pol, input bit dte,
                     input bit ih, input bit il, input bit mid, input int psc,
                     input int dth, input int dtl, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int t, c, c2;
      bit tk, pe, r, h, l;
      item_t it;
      t = k >> psc;
      tk = ((k + 1) % (1 << psc)) == 0;
      if (!ctr) begin
        c = t % p;
        pe = tk && (c == p - 1);
      end else begin
        c2 = t % (2 * p);
        c = (c2 <= p) ? c2 : 2 * p - c2;
        pe = tk && ((c2 == 2 * p - 1) || (mid && c2 == p - 1));
      end
      r = (c < d) ^ pol;
      if (r == m_prev) m_len++; else m_len = 1;
      m_prev = r;
      h = dte ? (r && m_len > dth) : r;
      l = dte ? (!r && m_len > dtl) : !r;
      it.v = {h ^ ih, l ^ il, pe, 1'b1};
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic gen_idle(input bit ih, input bit il, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.v = {ih, il, 1'b0, 1'b0};
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hi", {pwm_hi, 3'b000}, 4'b0000);
    chk("R1 lo", {pwm_lo, 3'b000}, 4'b0000);
    chk("R1 pe", {period_end, 3'b000}, 4'b0000);
    chk("R1 run", {running, 3'b000}, 4'b0000);
    @(posedge clk); #1;

    // R2 left-aligned basic
    cfg(md(0,0,0,0,0,0,0), 6, 2, 0, 0);
    start();
    gen(6, 2, 0,0,0,0,0,0, 0, 0, 0, 12, "R2 left P6 D2");
    halt();

    // R4 polarity and pin inversion
    cfg(md(0,1,0,1,0,0,0), 6, 2, 0, 0);
    start();
    gen(6, 2, 0,1,0,1,0,0, 0, 0, 0, 12, "R4 pol+invh");
    halt();

    // R5 dead-time with distinct high/low delays
    cfg(md(0,0,1,0,0,0,0), 10, 5, 2, 3);
    start();
    gen(10, 5, 0,0,1,0,0,0, 0, 2, 3, 30, "R5 dead-time H2 L3");
    halt();

    // R3 center-aligned
    cfg(md(1,0,0,0,0,0,0), 4, 2, 0, 0);
    start();
    gen(4, 2, 1,0,0,0,0,0, 0, 0, 0, 16, "R3 center P4");
    halt();

    // R3 R4 center with mid pulse, polarity, low inversion
    cfg(md(1,1,0,0,1,1,0), 3, 1, 0, 0);
    start();
    gen(3, 1, 1,1,0,0,1,1, 0, 0, 0, 12, "R3 R4 center mid");
    halt();

    // R2 full and zero duty with zero dead-time
    cfg(md(0,0,1,0,0,0,0), 3, 3, 0, 0);
    start();
    gen(3, 3, 0,0,1,0,0,0, 0, 0, 0, 6, "R2 duty=P");
    halt();
    cfg(md(0,0,1,0,0,0,0), 3, 0, 0, 0);
    start();
    gen(3, 0, 0,0,1,0,0,0, 0, 0, 0, 6, "R2 duty=0");
    halt();

    // R7 R8 shadowed writes while running
    cfg(md(0,0,0,0,0,0,0), 8, 3, 0, 0);
    start();
    gen(8, 3, 0,0,0,0,0,0, 0, 0, 0, 8, "R7 old values until boundary");
    gen(5, 4, 0,0,0,0,0,0, 0, 0, 0, 10, "R7 R8 new values, mode write ignored");
    wr(3'd1, 32'd5);
    wr(3'd2, 32'd4);
    wr(3'd0, md(0,0,0,1,1,0,0));
    halt();

    // R9 stop waits for end of period
    cfg(md(0,0,0,1,0,0,0), 5, 2, 0, 0);
    start();
    gen(5, 2, 0,0,0,1,0,0, 0, 0, 0, 5, "R9 runs to period end");
    gen_idle(1'b1, 1'b0, 4, "R9 R1 idle after stop");
    wr(3'd5, 32'd0);
    flush();

    // R10 prescaler 2^2
    cfg(md(0,0,0,0,0,0,2), 3, 1, 0, 0);
    start();
    gen(3, 1, 0,0,0,0,0,0, 2, 0, 0, 24, "R10 prescale 4");
    halt();

    report();
    $finish;
  end
endmodule